// File: doc/BRIEF.md
# Write Status Bit Generator

This block forms the read data bus of a flash array while an internal program or erase is in progress. Once an operation is armed, a read of an address inside the valid range does not return array contents. Bit 7 and bit 6 instead carry two separate completion indicators, and bits 5:0 read as zero. Bit 7 is tied to the operation: a program shows the inverse of bit 7 of the byte being written, and an erase shows 0. Bit 6 changes value on every completed read, so software polling it sees it alternate until the operation ends.

Status reporting is armed only when the busy flag is high and enough write strobes have been counted for the pending operation: four for a program and six for any erase. When busy drops there is a settling window of a parameterised number of cycles. During this window bit 7 already shows its final value, but the lower bits are not yet valid. After the window, reads return array data unchanged. The sequencing of the erase itself is handled outside this block.

Top module: `wsb_status_gen`

## Requirements
- R1: When busy is low and no settling window is open, rd_data equals array_data for every address.
- R2: While armed with op_kind 2'b00 (program), a read at an address below VALID_LIMIT returns bit 7 equal to the inverse of prog_data bit 7 and bits 5:0 equal to zero.
- R3: While armed with op_kind 2'b01, 2'b10 or 2'b11 (erase kinds), a read at an address below VALID_LIMIT returns bit 7 equal to 0 and bits 5:0 equal to zero.
- R4: Bit 6 of a status read is a toggle flag. The flag is 0 on the first cycle after arming. It inverts on the clock edge that detects the trailing (high-to-low) edge of rd_stb, provided status is armed and the address is below VALID_LIMIT.
- R5: The toggle flag holds its value while not armed, and a read trailing edge at an address at or above VALID_LIMIT leaves it unchanged.
- R6: Arming requires busy high and a count of write strobe trailing edges of at least 4 for a program or 6 for an erase. If busy is high with fewer strobes counted, rd_data equals array_data.
- R7: While armed, a read at an address at or above VALID_LIMIT returns array_data unchanged.
- R8: The settling window lasts SETTLE_CYC cycles and starts in the cycle arming ends. In that window rd_data bit 7 is array_data bit 7 after a program and 1 after an erase, bit 6 is the frozen toggle flag, and bits 5:0 are zero. After the window, R1 applies.
- R9: The write strobe count saturates at 7 and is cleared in the cycle after busy falls, so a later operation needs its full strobe count again.
- R10: A synchronous active-high reset clears the strobe count and the toggle flag and closes any settling window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_stb | input | 1 | Write strobe, active high; trailing edges are counted |
| rd_stb | input | 1 | Read strobe, active high; trailing edge advances the toggle flag |
| addr | input | ADDR_W | Read address |
| busy | input | 1 | Internal program or erase in progress |
| op_kind | input | 2 | 00 program, 01 sector erase, 10 block erase, 11 whole-array erase |
| prog_data | input | 8 | Latched byte being programmed |
| array_data | input | 8 | Data read from the array |
| rd_data | output | 8 | Read data bus returned to the host |

## Verification
The hardest situation to reach from the ports is the boundary between one operation and the next. This includes the settling window right after busy falls, the toggle flag freezing at whatever phase the last read left it, and the strobe counter being cleared so the next operation has to earn its arming again. The bench walks a program and then each erase kind in turn, with reads alternating between in-range and out-of-range addresses. Each completed operation is followed by cycle-exact sampling through the settling window and a busy-without-strobes probe. The toggle expectation is carried across operations in the bench.

// File: rtl/wsb_pkg.sv
package wsb_pkg;

    typedef enum logic [1:0] {
        OPK_PROGRAM = 2'b00,
        OPK_SECTOR  = 2'b01,
        OPK_BLOCK   = 2'b10,
        OPK_WHOLE   = 2'b11
    } op_kind_e;

    localparam int STB_CNT_W = 3;
    localparam logic [STB_CNT_W-1:0] PROG_ARM_STROBES  = 3'd4;
    localparam logic [STB_CNT_W-1:0] ERASE_ARM_STROBES = 3'd6;
    localparam logic [STB_CNT_W-1:0] STB_CNT_MAX       = 3'd7;

    typedef struct packed {
        logic       done_bit;
        logic       flip_bit;
        logic [5:0] rest;
    } stat_byte_t;

    typedef enum logic [1:0] {
        SRC_ARRAY,
        SRC_STATUS,
        SRC_SETTLE
    } rd_src_e;

    function automatic logic is_erase(op_kind_e k);
        return k != OPK_PROGRAM;
    endfunction

    function automatic logic [STB_CNT_W-1:0] arm_need(op_kind_e k);
        return is_erase(k) ? ERASE_ARM_STROBES : PROG_ARM_STROBES;
    endfunction

endpackage

// File: rtl/wsb_strobe_count.sv
module wsb_strobe_count
    import wsb_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_stb,
    input  logic                 busy,
    output logic [STB_CNT_W-1:0] count
);
    logic wr_q;
    logic busy_q;
    logic wr_trail;
    logic busy_end;

    assign wr_trail = wr_q & ~wr_stb;
    assign busy_end = busy_q & ~busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q   <= 1'b0;
            busy_q <= 1'b0;
            count  <= '0;
        end else begin
            wr_q   <= wr_stb;
            busy_q <= busy;
            if (busy_end)
                count <= '0;
            else if (wr_trail && count != STB_CNT_MAX)
                count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/wsb_toggle.sv
module wsb_toggle (
    input  logic clk,
    input  logic rst,
    input  logic rd_stb,
    input  logic armed,
    input  logic arm_start,
    input  logic addr_ok,
    output logic tgl
);
    logic rd_q;
    logic rd_trail;

    assign rd_trail = rd_q & ~rd_stb;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q <= 1'b0;
            tgl  <= 1'b0;
        end else begin
            rd_q <= rd_stb;
            if (arm_start)
                tgl <= 1'b0;
            else if (armed && addr_ok && rd_trail)
                tgl <= ~tgl;
        end
    end
endmodule

// File: rtl/wsb_settle.sv
module wsb_settle #(
    parameter int SETTLE_CYC = 33
) (
    input  logic clk,
    input  logic rst,
    input  logic armed,
    output logic armed_q,
    output logic settling
);
    localparam int CW = $clog2(SETTLE_CYC + 1);
    localparam logic [CW-1:0] LOAD_V = CW'(SETTLE_CYC - 1);

    logic [CW-1:0] remain;
    logic          arm_end;

    assign arm_end  = armed_q & ~armed;
    assign settling = arm_end | (remain != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b0;
            remain  <= '0;
        end else begin
            armed_q <= armed;
            if (armed)
                remain <= '0;
            else if (arm_end)
                remain <= LOAD_V;
            else if (remain != '0)
                remain <= remain - 1'b1;
        end
    end
endmodule

// File: rtl/wsb_status_gen.sv
module wsb_status_gen
    import wsb_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int VALID_LIMIT = 200,
    parameter int SETTLE_CYC  = 33
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_stb,
    input  logic              rd_stb,
    input  logic [ADDR_W-1:0] addr,
    input  logic              busy,
    input  logic [1:0]        op_kind,
    input  logic [7:0]        prog_data,
    input  logic [7:0]        array_data,
    output logic [7:0]        rd_data
);
    localparam logic [ADDR_W:0] LIMIT_V = (ADDR_W + 1)'(VALID_LIMIT);

    op_kind_e              kind;
    logic [STB_CNT_W-1:0]  stb_count;
    logic                  armed;
    logic                  armed_q;
    logic                  arm_start;
    logic                  settling;
    logic                  addr_ok;
    logic                  tgl;
    logic                  last_erase;
    rd_src_e               src;
    stat_byte_t            stat;

    assign kind      = op_kind_e'(op_kind);
    assign addr_ok   = ({1'b0, addr} < LIMIT_V);
    assign armed     = busy && (stb_count >= arm_need(kind));
    assign arm_start = armed & ~armed_q;

    wsb_strobe_count u_cnt (
        .clk    (clk),
        .rst    (rst),
        .wr_stb (wr_stb),
        .busy   (busy),
        .count  (stb_count)
    );

    wsb_toggle u_tgl (
        .clk       (clk),
        .rst       (rst),
        .rd_stb    (rd_stb),
        .armed     (armed),
        .arm_start (arm_start),
        .addr_ok   (addr_ok),
        .tgl       (tgl)
    );

    wsb_settle #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
        .clk      (clk),
        .rst      (rst),
        .armed    (armed),
        .armed_q  (armed_q),
        .settling (settling)
    );

    always_ff @(posedge clk) begin
        if (rst)
            last_erase <= 1'b0;
        else if (armed)
            last_erase <= is_erase(kind);
    end

    always_comb begin
        if (armed)
            src = addr_ok ? SRC_STATUS : SRC_ARRAY;
        else if (settling)
            src = SRC_SETTLE;
        else
            src = SRC_ARRAY;
    end

    always_comb begin
        stat = '0;
        unique case (src)
            SRC_STATUS: begin
                stat.done_bit = is_erase(kind) ? 1'b0 : ~prog_data[7];
                stat.flip_bit = tgl;
            end
            SRC_SETTLE: begin
                stat.done_bit = last_erase ? 1'b1 : array_data[7];
                stat.flip_bit = tgl;
            end
            default: stat = stat_byte_t'(array_data);
        endcase
        rd_data = stat;
    end
endmodule

// File: rtl/wsb_status_chk.sv
module wsb_status_chk #(
    parameter int ADDR_W      = 8,
    parameter int VALID_LIMIT = 200
) (
    input logic              clk,
    input logic              rst,
    input logic              rd_stb,
    input logic              busy,
    input logic [ADDR_W-1:0] addr,
    input logic [1:0]        op_kind,
    input logic [7:0]        prog_data,
    input logic [7:0]        array_data,
    input logic [7:0]        rd_data,
    input logic              armed,
    input logic              settling,
    input logic              tgl
);
    logic in_range;
    assign in_range = (int'(addr) < VALID_LIMIT);

    p_idle_pass_r1: assert property (@(posedge clk) disable iff (rst)
        (!busy && !settling) |-> rd_data == array_data);

    p_prog_bit7_r2: assert property (@(posedge clk) disable iff (rst)
        (armed && in_range && op_kind == 2'b00) |->
            (rd_data[7] == !prog_data[7] && rd_data[5:0] == 6'd0));

    p_erase_bit7_r3: assert property (@(posedge clk) disable iff (rst)
        (armed && in_range && op_kind != 2'b00) |-> rd_data[7] == 1'b0);

    p_tgl_flip_r4: assert property (@(posedge clk) disable iff (rst)
        (armed && $past(armed) && $past(rd_stb) && !rd_stb && in_range)
            |=> tgl != $past(tgl));

    p_tgl_idle_r5: assert property (@(posedge clk) disable iff (rst)
        !armed |=> $stable(tgl));

    p_tgl_range_r5: assert property (@(posedge clk) disable iff (rst)
        (armed && $past(armed) && !in_range) |=> $stable(tgl));

    p_unarmed_pass_r6: assert property (@(posedge clk) disable iff (rst)
        (busy && !armed && !settling) |-> rd_data == array_data);

    p_range_pass_r7: assert property (@(posedge clk) disable iff (rst)
        (armed && !in_range) |-> rd_data == array_data);

    p_settle_open_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(armed) |-> (settling && rd_data[5:0] == 6'd0));
endmodule

bind wsb_status_gen wsb_status_chk #(
    .ADDR_W      (ADDR_W),
    .VALID_LIMIT (VALID_LIMIT)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .rd_stb     (rd_stb),
    .busy       (busy),
    .addr       (addr),
    .op_kind    (op_kind),
    .prog_data  (prog_data),
    .array_data (array_data),
    .rd_data    (rd_data),
    .armed      (armed),
    .settling   (settling),
    .tgl        (tgl)
);

// File: tb/tb_wsb_status_gen.sv
`timescale 1ns/1ps
module tb_wsb_status_gen;
    localparam int AW     = 4;
    localparam int LIMIT  = 12;
    localparam int SETTLE = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_stb = 1'b0;
    logic          rd_stb = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          busy = 1'b0;
    logic [1:0]    op_kind = 2'b00;
    logic [7:0]    prog_data = '0;
    logic [7:0]    array_data = '0;
    logic [7:0]    rd_data;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;
    logic exp_tgl = 1'b0;

    always #5 clk = ~clk;

    wsb_status_gen #(.ADDR_W(AW), .VALID_LIMIT(LIMIT), .SETTLE_CYC(SETTLE)) dut (
        .clk(clk), .rst(rst), .wr_stb(wr_stb), .rd_stb(rd_stb), .addr(addr),
        .busy(busy), .op_kind(op_kind), .prog_data(prog_data),
        .array_data(array_data), .rd_data(rd_data)
    );

    task automatic check(input string tag, input logic [7:0] exp);
        n_chk++;
        if (rd_data !== exp) begin
            n_bad++;
            $display("FAIL %s: rd_data=%02h expected=%02h", tag, rd_data, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic sample();
        @(negedge clk);
    endtask

    task automatic wr_pulse();
        step(); wr_stb = 1'b1;
        step(); wr_stb = 1'b0;
        step();
    endtask

    function automatic logic [7:0] pat(input int i);
        return 8'((i * 37 + 11) ^ (i << 3));
    endfunction

    // one complete read; expected data computed from the requirements
    task automatic do_read(input int a, input logic [7:0] arr, input logic [7:0] pd,
                           input bit erase, input string tag);
        logic [7:0] exp;
        step();
        addr = AW'(a); array_data = arr; prog_data = pd; rd_stb = 1'b1;
        if (a < LIMIT) exp = {(erase ? 1'b0 : ~pd[7]), exp_tgl, 6'd0};
        else           exp = arr;
        sample();
        check(tag, exp);
        step(); rd_stb = 1'b0;
        if (a < LIMIT) exp_tgl = ~exp_tgl;
    endtask

    task automatic settle_walk(input bit erase);
        step(); busy = 1'b0; array_data = 8'h35; addr = 4'd2;
        for (int c = 0; c < SETTLE; c++) begin
            sample();
            check(erase ? "R8 settle erase" : "R8 settle prog",
                  {(erase ? 1'b1 : array_data[7]), exp_tgl, 6'd0});
            step(); array_data = array_data ^ 8'h80;
        end
        sample();
        check("R8 window end -> R1", array_data);
        // R9: strobe count cleared, busy alone does not arm
        step(); busy = 1'b1; array_data = 8'hC3;
        sample();
        check("R9 count cleared", 8'hC3);
        step(); busy = 1'b0;
        step();
    endtask

    initial begin
        step(); step();
        sample();
        array_data = 8'h9E;
        #1 check("R10 reset state", 8'h9E);
        step(); rst = 1'b0;

        // R1: idle passthrough sweep over every address
        for (int a = 0; a < 16; a++) begin
            step(); addr = AW'(a); array_data = pat(a);
            sample();
            check("R1 idle pass", pat(a));
        end

        // Program: 3 strobes then busy -> not armed
        op_kind = 2'b00; prog_data = 8'hA5;
        for (int i = 0; i < 3; i++) wr_pulse();
        busy = 1'b1; addr = 4'd1; array_data = 8'h77;
        sample();
        check("R6 prog 3 strobes unarmed", 8'h77);
        wr_pulse();
        step();
        exp_tgl = 1'b0;
        // reads over all addresses, valid and invalid
        for (int a = 0; a < 16; a++)
            do_read(a, pat(a + 3), pat(a * 5), 1'b0,
                    (a < LIMIT) ? "R2/R4 prog status" : "R7 out of range");
        // R5: out-of-range read must not move the flag; next valid read shows it
        do_read(14, 8'h12, 8'h00, 1'b0, "R7 out of range");
        do_read(3, 8'h12, 8'h00, 1'b0, "R5 flag kept after invalid read");
        // R2: bit7 against every prog_data value, no reads
        for (int v = 0; v < 256; v++) begin
            step(); addr = 4'd0; prog_data = 8'(v); array_data = 8'(255 - v);
            sample();
            check("R2 prog bit7 sweep", {~prog_data[7], exp_tgl, 6'd0});
        end
        settle_walk(1'b0);

        // Each erase kind
        for (int k = 1; k < 4; k++) begin
            op_kind = 2'(k);
            for (int i = 0; i < 4; i++) wr_pulse();
            busy = 1'b1; addr = 4'd5; array_data = 8'h5C;
            sample();
            check("R6 erase 4 strobes unarmed", 8'h5C);
            wr_pulse(); wr_pulse();
            step();
            exp_tgl = 1'b0;
            for (int a = 0; a < 16; a += 3)
                do_read(a, pat(a + k), pat(a), 1'b1,
                        (a < LIMIT) ? "R3/R4 erase status" : "R7 out of range");
            // R5: flag frozen once no longer armed is covered by settle_walk
            settle_walk(1'b1);
        end

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule